// File: doc/BRIEF.md
# Vector Instruction Expansion Sequencer

This block sits directly behind instruction decode. It takes one three-operand instruction in scalar form: an operation code, a destination and two source register indices. Each operand arrives with a flag that marks it as a vector and a length counted in registers. The instruction also carries an element-width code, an active element count and a predicate mask with one bit per element. From this the block produces a stream of element-level micro-operations, one per output cycle. Each micro-operation names, for every operand, a physical register and the bit range of the subword inside it. The ALU and the register file stay outside. The block only generates addresses and decides which elements are issued.

An operand flagged as a vector walks forward through packed subwords. It rolls into the next register once the current one is full. A scalar operand stays on slot 0 of its base register for every element. Predicate bits and the active count remove elements. A removed element takes no output cycle. Mismatched operand lengths are rejected with a trap instead of micro-operations. An instruction with only scalar operands and the default width goes out once, unchanged.

Top module: `vexp_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `inReady` is 1, `outValid` is 0, `done` is 0 and `trap` is 0.
- R2: At element index i, an operand flagged as a vector uses register base + floor(i / M), where M = XLEN / element width and indices wrap modulo 2^REG_W. An operand not flagged uses its base register and slot 0 for every element. Example: default width, scalar destination r2, vector sources r4 and r4, count 3 gives (r2,r4,r4), (r2,r5,r5), (r2,r6,r6).
- R3: Width code 1, 2 and 3 select 8, 16 and 32-bit elements. Code 0, and any code whose width is reserved (6, 7) or wider than XLEN, selects the full XLEN. A vector operand at element i occupies bits [s*w + w - 1 : s*w], with s = i mod M.
- R4: Element i is issued only if predicate bit i is 1. Elements are issued in rising index order. After a handshake, the next enabled element is offered in the very next cycle, so masked elements take no output cycle.
- R5: Elements at an index of at least the active count are never issued. Counts above MAX_ELEMS are clamped to MAX_ELEMS, and a count of 0 issues nothing.
- R6: A trap is raised, and nothing is issued, when both sources are vectors with unequal lengths. It is also raised when the destination is a vector, at least one source is a vector, and the destination length is smaller than that source's length. `trap` is high only in the `done` cycle.
- R7: If no operand is flagged and the width resolves to full XLEN, exactly one micro-operation goes out: element index 0, base registers and bits [XLEN-1:0]. The predicate and the active count are ignored.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and every output field holds its value.
- R9: `done` pulses for exactly one cycle, one cycle after the last issued element or after the rejection decision. `inReady` is 1 only when no instruction is in progress, so the next instruction is accepted only after `done`.
- R10: Every micro-operation carries the accepted operation code unchanged and, in `outIdx`, its element index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Sequencer idle and able to accept |
| inOp | input | OP_W | Operation code |
| inRd | input | REG_W | Destination base register |
| inRs1 | input | REG_W | First source base register |
| inRs2 | input | REG_W | Second source base register |
| inRdVec | input | 1 | Destination is a vector |
| inRs1Vec | input | 1 | First source is a vector |
| inRs2Vec | input | 1 | Second source is a vector |
| inRdLen | input | RLEN_W | Destination length in registers |
| inRs1Len | input | RLEN_W | First source length in registers |
| inRs2Len | input | RLEN_W | Second source length in registers |
| inWidth | input | 3 | Element width code |
| inActLen | input | IDX_W | Active element count |
| inPred | input | MAX_ELEMS | Predicate, bit i enables element i |
| outValid | output | 1 | Micro-operation offered |
| outReady | input | 1 | Consumer takes the micro-operation |
| outOp | output | OP_W | Operation code |
| outIdx | output | IDX_W | Element index |
| outRdReg | output | REG_W | Destination physical register |
| outRdLo | output | XLOG | Destination low bit |
| outRdHi | output | XLOG | Destination high bit |
| outRs1Reg | output | REG_W | First source physical register |
| outRs1Lo | output | XLOG | First source low bit |
| outRs1Hi | output | XLOG | First source high bit |
| outRs2Reg | output | REG_W | Second source physical register |
| outRs2Lo | output | XLOG | Second source low bit |
| outRs2Hi | output | XLOG | Second source high bit |
| done | output | 1 | One-cycle end-of-instruction pulse |
| trap | output | 1 | Instruction rejected (with done) |

## Verification
The assertions watch the properties that must hold on every cycle:
- the single-cycle `done` pulse;
- idle acceptance never overlapping an offered micro-operation;
- frozen outputs under backpressure;
- a trap appearing only with `done` and no micro-operation;
- equal subword widths across the three operands;
- strictly rising element indices.

Only the bench scenarios can show that the right elements appear at the right registers and bit ranges. This covers scalar reuse, the subword rollover into the next register, predicate and count masking, the pass-through case, and the two length-mismatch traps. The bench also shows that skipped elements cost no output cycle.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seqStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new instruction
    logic step;  // current element handed over, move past it
  } dpStrobeT;
endpackage

// File: rtl/vexp_opnd_map.sv
// Maps an element index to a physical register and subword bit range
module vexp_opnd_map #(
  parameter int XLEN  = 32,
  parameter int REG_W = 5,
  parameter int IDX_W = 7,
  parameter int XLOG  = $clog2(XLEN),
  parameter int ELW   = $clog2(XLOG + 1)
) (
  input  logic [REG_W-1:0] base,
  input  logic             isVec,
  input  logic [IDX_W-1:0] elemIdx,
  input  logic [ELW-1:0]   elemLog,
  output logic [REG_W-1:0] physReg,
  output logic [XLOG-1:0]  bitLo,
  output logic [XLOG-1:0]  bitHi
);
  logic [ELW-1:0]   multLog;
  logic [IDX_W-1:0] effIdx;
  logic [IDX_W-1:0] regOff;
  logic [IDX_W-1:0] slot;
  logic [XLOG:0]    loWide;
  logic [XLOG:0]    hiWide;

  always_comb begin
    multLog = ELW'(XLOG) - elemLog;
    effIdx  = isVec ? elemIdx : '0;
    regOff  = effIdx >> multLog;
    slot    = effIdx & ((IDX_W'(1) << multLog) - IDX_W'(1));
    loWide  = (XLOG + 1)'(slot) << elemLog;
    hiWide  = loWide + (((XLOG + 1)'(1)) << elemLog) - (XLOG + 1)'(1);
    physReg = base + REG_W'(regOff);
    bitLo   = loWide[XLOG-1:0];
    bitHi   = hiWide[XLOG-1:0];
  end
endmodule

// File: rtl/vexp_ctrl.sv
module vexp_ctrl
  import vexp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     outReady,
  input  logic     hasNext,
  input  logic     excFlag,
  output logic     inReady,
  output logic     outValid,
  output logic     done,
  output logic     trap,
  output dpStrobeT strobe
);
  seqStateT state, stateNxt;

  always_comb begin
    inReady     = (state == ST_IDLE);
    outValid    = (state == ST_RUN) && hasNext && !excFlag;
    done        = (state == ST_FIN);
    trap        = (state == ST_FIN) && excFlag;
    strobe.load = inReady && inValid;
    strobe.step = outValid && outReady;
    stateNxt    = state;
    unique case (state)
      ST_IDLE: if (inValid) stateNxt = ST_RUN;
      ST_RUN:  if (excFlag || !hasNext) stateNxt = ST_FIN;
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end
endmodule

// File: rtl/vexp_dp.sv
module vexp_dp
  import vexp_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_W     = 5,
  parameter int OP_W      = 8,
  parameter int MAX_ELEMS = 64,
  parameter int RLEN_W    = 5,
  parameter int XLOG      = $clog2(XLEN),
  parameter int IDX_W     = $clog2(MAX_ELEMS + 1),
  parameter int ELW       = $clog2(XLOG + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dpStrobeT                   strobe,
  input  logic [OP_W-1:0]            inOp,
  input  logic [2:0][REG_W-1:0]      inBase,
  input  logic [2:0]                 inVec,
  input  logic [RLEN_W-1:0]          inRdLen,
  input  logic [RLEN_W-1:0]          inRs1Len,
  input  logic [RLEN_W-1:0]          inRs2Len,
  input  logic [2:0]                 inWidth,
  input  logic [IDX_W-1:0]           inActLen,
  input  logic [MAX_ELEMS-1:0]       inPred,
  output logic                       hasNext,
  output logic                       excFlag,
  output logic [OP_W-1:0]            outOp,
  output logic [IDX_W-1:0]           outIdx,
  output logic [2:0][REG_W-1:0]      opReg,
  output logic [2:0][XLOG-1:0]       opLo,
  output logic [2:0][XLOG-1:0]       opHi
);
  // Captured instruction
  logic [OP_W-1:0]        opQ;
  logic [2:0][REG_W-1:0]  baseQ;
  logic [2:0]             vecQ;
  logic [ELW-1:0]         elemLogQ;
  logic [IDX_W-1:0]       cntQ;
  logic [MAX_ELEMS-1:0]   predQ;
  logic                   passQ;
  logic                   excQ;
  logic [IDX_W-1:0]       cursor;

  // Decode of the offered instruction
  logic                   codeOk;
  logic [ELW-1:0]         elemLogIn;
  logic                   passIn;
  logic                   excIn;
  logic [RLEN_W-1:0]      srcLen;
  logic [IDX_W-1:0]       cntIn;
  logic [IDX_W-1:0]       cntEff;
  logic [IDX_W-1:0]       nextIdx;

  always_comb begin
    codeOk    = (inWidth != 3'd0) && ((int'(inWidth) + 2) <= XLOG);
    elemLogIn = codeOk ? ELW'(int'(inWidth) + 2) : ELW'(XLOG);
    passIn    = !(|inVec) && !codeOk;
    srcLen    = inVec[1] ? inRs1Len : inRs2Len;
    excIn     = (inVec[1] && inVec[2] && (inRs1Len != inRs2Len)) ||
                (inVec[0] && (inVec[1] || inVec[2]) && (inRdLen < srcLen));
    cntIn     = (inActLen > IDX_W'(MAX_ELEMS)) ? IDX_W'(MAX_ELEMS) : inActLen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opQ      <= '0;
      baseQ    <= '0;
      vecQ     <= '0;
      elemLogQ <= ELW'(XLOG);
      cntQ     <= '0;
      predQ    <= '0;
      passQ    <= 1'b0;
      excQ     <= 1'b0;
      cursor   <= '0;
    end else if (strobe.load) begin
      opQ      <= inOp;
      baseQ    <= inBase;
      vecQ     <= inVec;
      elemLogQ <= elemLogIn;
      cntQ     <= cntIn;
      predQ    <= inPred;
      passQ    <= passIn;
      excQ     <= excIn;
      cursor   <= '0;
    end else if (strobe.step) begin
      cursor   <= nextIdx + IDX_W'(1);
    end
  end

  // Lowest enabled element at or above the cursor, found in one cycle
  always_comb begin
    cntEff  = passQ ? IDX_W'(1) : cntQ;
    hasNext = 1'b0;
    nextIdx = '0;
    for (int k = MAX_ELEMS - 1; k >= 0; k--) begin
      if ((IDX_W'(k) < cntEff) && (IDX_W'(k) >= cursor) && (passQ || predQ[k])) begin
        hasNext = 1'b1;
        nextIdx = IDX_W'(k);
      end
    end
  end

  assign excFlag = excQ;
  assign outOp   = opQ;
  assign outIdx  = nextIdx;

  for (genvar g = 0; g < 3; g++) begin : g_opnd
    vexp_opnd_map #(
      .XLEN (XLEN),
      .REG_W(REG_W),
      .IDX_W(IDX_W)
    ) u_map (
      .base   (baseQ[g]),
      .isVec  (vecQ[g]),
      .elemIdx(nextIdx),
      .elemLog(elemLogQ),
      .physReg(opReg[g]),
      .bitLo  (opLo[g]),
      .bitHi  (opHi[g])
    );
  end
endmodule

// File: rtl/vexp_seq.sv
module vexp_seq
  import vexp_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_W     = 5,
  parameter int OP_W      = 8,
  parameter int MAX_ELEMS = 64,
  parameter int RLEN_W    = 5,
  localparam int XLOG     = $clog2(XLEN),
  localparam int IDX_W    = $clog2(MAX_ELEMS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [OP_W-1:0]      inOp,
  input  logic [REG_W-1:0]     inRd,
  input  logic [REG_W-1:0]     inRs1,
  input  logic [REG_W-1:0]     inRs2,
  input  logic                 inRdVec,
  input  logic                 inRs1Vec,
  input  logic                 inRs2Vec,
  input  logic [RLEN_W-1:0]    inRdLen,
  input  logic [RLEN_W-1:0]    inRs1Len,
  input  logic [RLEN_W-1:0]    inRs2Len,
  input  logic [2:0]           inWidth,
  input  logic [IDX_W-1:0]     inActLen,
  input  logic [MAX_ELEMS-1:0] inPred,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [OP_W-1:0]      outOp,
  output logic [IDX_W-1:0]     outIdx,
  output logic [REG_W-1:0]     outRdReg,
  output logic [XLOG-1:0]      outRdLo,
  output logic [XLOG-1:0]      outRdHi,
  output logic [REG_W-1:0]     outRs1Reg,
  output logic [XLOG-1:0]      outRs1Lo,
  output logic [XLOG-1:0]      outRs1Hi,
  output logic [REG_W-1:0]     outRs2Reg,
  output logic [XLOG-1:0]      outRs2Lo,
  output logic [XLOG-1:0]      outRs2Hi,
  output logic                 done,
  output logic                 trap
);
  dpStrobeT              strobe;
  logic                  hasNext;
  logic                  excFlag;
  logic [2:0][REG_W-1:0] opReg;
  logic [2:0][XLOG-1:0]  opLo;
  logic [2:0][XLOG-1:0]  opHi;

  vexp_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .outReady(outReady),
    .hasNext (hasNext),
    .excFlag (excFlag),
    .inReady (inReady),
    .outValid(outValid),
    .done    (done),
    .trap    (trap),
    .strobe  (strobe)
  );

  vexp_dp #(
    .XLEN     (XLEN),
    .REG_W    (REG_W),
    .OP_W     (OP_W),
    .MAX_ELEMS(MAX_ELEMS),
    .RLEN_W   (RLEN_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inOp    (inOp),
    .inBase  ({inRs2, inRs1, inRd}),
    .inVec   ({inRs2Vec, inRs1Vec, inRdVec}),
    .inRdLen (inRdLen),
    .inRs1Len(inRs1Len),
    .inRs2Len(inRs2Len),
    .inWidth (inWidth),
    .inActLen(inActLen),
    .inPred  (inPred),
    .hasNext (hasNext),
    .excFlag (excFlag),
    .outOp   (outOp),
    .outIdx  (outIdx),
    .opReg   (opReg),
    .opLo    (opLo),
    .opHi    (opHi)
  );

  assign outRdReg  = opReg[0];
  assign outRdLo   = opLo[0];
  assign outRdHi   = opHi[0];
  assign outRs1Reg = opReg[1];
  assign outRs1Lo  = opLo[1];
  assign outRs1Hi  = opHi[1];
  assign outRs2Reg = opReg[2];
  assign outRs2Lo  = opLo[2];
  assign outRs2Hi  = opHi[2];
endmodule

// File: rtl/vexp_chk.sv
module vexp_chk #(
  parameter int XLEN      = 32,
  parameter int REG_W     = 5,
  parameter int OP_W      = 8,
  parameter int MAX_ELEMS = 64,
  localparam int XLOG     = $clog2(XLEN),
  localparam int IDX_W    = $clog2(MAX_ELEMS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [OP_W-1:0]  outOp,
  input logic [IDX_W-1:0] outIdx,
  input logic [REG_W-1:0] outRdReg,
  input logic [XLOG-1:0]  outRdLo,
  input logic [XLOG-1:0]  outRdHi,
  input logic [REG_W-1:0] outRs1Reg,
  input logic [XLOG-1:0]  outRs1Lo,
  input logic [XLOG-1:0]  outRs1Hi,
  input logic [REG_W-1:0] outRs2Reg,
  input logic [XLOG-1:0]  outRs2Lo,
  input logic [XLOG-1:0]  outRs2Hi,
  input logic             done,
  input logic             trap
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_idle_excl: assert property (@(posedge clk) disable iff (rst)
    inReady |-> !outValid);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outIdx) && $stable(outOp) &&
      $stable(outRdReg) && $stable(outRdLo) && $stable(outRdHi) &&
      $stable(outRs1Reg) && $stable(outRs1Lo) && $stable(outRs1Hi) &&
      $stable(outRs2Reg) && $stable(outRs2Lo) && $stable(outRs2Hi)));

  a_r6_trap_with_done: assert property (@(posedge clk) disable iff (rst)
    trap |-> (done && !outValid));

  a_r3_equal_slices: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ((outRdHi >= outRdLo) &&
                  ((outRdHi - outRdLo) == (outRs1Hi - outRs1Lo)) &&
                  ((outRdHi - outRdLo) == (outRs2Hi - outRs2Lo))));

  a_r4_rising_index: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |=> (!outValid || (outIdx > $past(outIdx))));
endmodule

bind vexp_seq vexp_chk #(
  .XLEN     (XLEN),
  .REG_W    (REG_W),
  .OP_W     (OP_W),
  .MAX_ELEMS(MAX_ELEMS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outOp    (outOp),
  .outIdx   (outIdx),
  .outRdReg (outRdReg),
  .outRdLo  (outRdLo),
  .outRdHi  (outRdHi),
  .outRs1Reg(outRs1Reg),
  .outRs1Lo (outRs1Lo),
  .outRs1Hi (outRs1Hi),
  .outRs2Reg(outRs2Reg),
  .outRs2Lo (outRs2Lo),
  .outRs2Hi (outRs2Hi),
  .done     (done),
  .trap     (trap)
);

// File: tb/sim_vexp_seq.sv
module sim_vexp_seq;
  localparam int XLEN = 32, XLOG = 5, REG_W = 5, OP_W = 8, MAXE = 64, IDX_W = 7, RLEN_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, outReady = 1'b0;
  logic [OP_W-1:0] inOp = '0;
  logic [REG_W-1:0] inRd = '0, inRs1 = '0, inRs2 = '0;
  logic inRdVec = 1'b0, inRs1Vec = 1'b0, inRs2Vec = 1'b0;
  logic [RLEN_W-1:0] inRdLen = '0, inRs1Len = '0, inRs2Len = '0;
  logic [2:0] inWidth = '0;
  logic [IDX_W-1:0] inActLen = '0;
  logic [MAXE-1:0] inPred = '0;
  logic inReady, outValid, done, trap;
  logic [OP_W-1:0] outOp;
  logic [IDX_W-1:0] outIdx;
  logic [REG_W-1:0] outRdReg, outRs1Reg, outRs2Reg;
  logic [XLOG-1:0] outRdLo, outRdHi, outRs1Lo, outRs1Hi, outRs2Lo, outRs2Hi;

  always #4 clk = ~clk;  // 125 MHz

  vexp_seq u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inOp(inOp),
    .inRd(inRd), .inRs1(inRs1), .inRs2(inRs2),
    .inRdVec(inRdVec), .inRs1Vec(inRs1Vec), .inRs2Vec(inRs2Vec),
    .inRdLen(inRdLen), .inRs1Len(inRs1Len), .inRs2Len(inRs2Len),
    .inWidth(inWidth), .inActLen(inActLen), .inPred(inPred),
    .outValid(outValid), .outReady(outReady), .outOp(outOp), .outIdx(outIdx),
    .outRdReg(outRdReg), .outRdLo(outRdLo), .outRdHi(outRdHi),
    .outRs1Reg(outRs1Reg), .outRs1Lo(outRs1Lo), .outRs1Hi(outRs1Hi),
    .outRs2Reg(outRs2Reg), .outRs2Lo(outRs2Lo), .outRs2Hi(outRs2Hi),
    .done(done), .trap(trap)
  );

  int nCmp = 0, nBad = 0, cycles = 0;

  // Test instruction
  int tOp, tW, tAct, tLen[3], tBase[3];
  bit tVec[3];
  logic [63:0] tPred;

  // Expected stream
  int eCnt;
  bit eTrap;
  int eIdx[MAXE];
  int eReg[MAXE][3], eLo[MAXE][3], eHi[MAXE][3];

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nCmp++; nBad++;
      $display("FAIL R9 watchdog expired: got %0d cycles, expected fewer", cycles);
      finishRun();
    end
  end

  task automatic check(input string tag, input bit ok, input int got, input int exp, input string what);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic computeExp();
    bit codeOk, pass;
    int el, ml, srcLen;
    codeOk = (tW != 0) && (tW + 2 <= XLOG);
    el = codeOk ? tW + 2 : XLOG;
    ml = XLOG - el;
    pass = !tVec[0] && !tVec[1] && !tVec[2] && !codeOk;
    srcLen = tVec[1] ? tLen[1] : tLen[2];
    eTrap = (tVec[1] && tVec[2] && tLen[1] != tLen[2]) ||
            (tVec[0] && (tVec[1] || tVec[2]) && tLen[0] < srcLen);
    eCnt = 0;
    if (eTrap) return;
    if (pass) begin
      eIdx[0] = 0;
      for (int o = 0; o < 3; o++) begin
        eReg[0][o] = tBase[o]; eLo[0][o] = 0; eHi[0][o] = XLEN - 1;
      end
      eCnt = 1;
      return;
    end
    for (int i = 0; i < ((tAct > MAXE) ? MAXE : tAct); i++) begin
      if (tPred[i]) begin
        eIdx[eCnt] = i;
        for (int o = 0; o < 3; o++) begin
          int off, slot;
          off  = tVec[o] ? (i >> ml) : 0;
          slot = tVec[o] ? (i & ((1 << ml) - 1)) : 0;
          eReg[eCnt][o] = (tBase[o] + off) % 32;
          eLo[eCnt][o]  = slot << el;
          eHi[eCnt][o]  = (slot << el) + (1 << el) - 1;
        end
        eCnt++;
      end
    end
  endtask

  task automatic runInstr(input string tag, input bit bp, input bit chkCycles);
    int got, cyc;
    bit fin, busyBad, gotTrap;
    computeExp();
    @(negedge clk);
    inOp = OP_W'(tOp);
    inRd = REG_W'(tBase[0]); inRs1 = REG_W'(tBase[1]); inRs2 = REG_W'(tBase[2]);
    inRdVec = tVec[0]; inRs1Vec = tVec[1]; inRs2Vec = tVec[2];
    inRdLen = RLEN_W'(tLen[0]); inRs1Len = RLEN_W'(tLen[1]); inRs2Len = RLEN_W'(tLen[2]);
    inWidth = 3'(tW); inActLen = IDX_W'(tAct); inPred = tPred;
    inValid = 1'b1;
    check("R9", inReady === 1'b1, int'(inReady), 1, "idle before accept");
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    got = 0; cyc = 0; fin = 0; busyBad = 0; gotTrap = 0;
    while (!fin && cyc < 2000) begin
      if (done === 1'b1) begin
        fin = 1; gotTrap = trap;
      end else begin
        bit rdy;
        if (inReady !== 1'b0) busyBad = 1;
        rdy = bp ? ($urandom % 3 != 0) : 1'b1;
        outReady = rdy;
        if (outValid === 1'b1 && rdy) begin
          if (got >= eCnt) begin
            nCmp++; nBad++;
            $display("FAIL %s extra uop idx %0d: got %0d uops expected %0d", tag, outIdx, got + 1, eCnt);
          end else begin
            bit ok;
            ok = (int'(outIdx) == eIdx[got]) && (int'(outOp) == tOp) &&
                 (int'(outRdReg) == eReg[got][0]) && (int'(outRdLo) == eLo[got][0]) && (int'(outRdHi) == eHi[got][0]) &&
                 (int'(outRs1Reg) == eReg[got][1]) && (int'(outRs1Lo) == eLo[got][1]) && (int'(outRs1Hi) == eHi[got][1]) &&
                 (int'(outRs2Reg) == eReg[got][2]) && (int'(outRs2Lo) == eLo[got][2]) && (int'(outRs2Hi) == eHi[got][2]);
            nCmp++;
            if (!ok) begin
              nBad++;
              $display("FAIL %s/R10 uop %0d: got idx %0d op %0d rd r%0d[%0d:%0d] rs1 r%0d[%0d:%0d] rs2 r%0d[%0d:%0d] expected idx %0d op %0d rd r%0d[%0d:%0d] rs1 r%0d[%0d:%0d] rs2 r%0d[%0d:%0d]",
                tag, got, outIdx, outOp, outRdReg, outRdHi, outRdLo, outRs1Reg, outRs1Hi, outRs1Lo,
                outRs2Reg, outRs2Hi, outRs2Lo, eIdx[got], tOp, eReg[got][0], eHi[got][0], eLo[got][0],
                eReg[got][1], eHi[got][1], eLo[got][1], eReg[got][2], eHi[got][2], eLo[got][2]);
            end
          end
          got++;
        end
        cyc++;
        @(negedge clk);
      end
    end
    outReady = 1'b0;
    check("R9", fin, int'(fin), 1, "done seen");
    check(tag, got == eCnt, got, eCnt, "uop count");
    check("R6", gotTrap == eTrap, int'(gotTrap), int'(eTrap), "trap flag");
    check("R9", !busyBad, int'(busyBad), 0, "inReady low while busy");
    if (chkCycles) check("R4", cyc == eCnt + 1, cyc, eCnt + 1, "cycles before done");
  endtask

  task automatic setInstr(input int op, input int rd, input bit rdV, input int rdL,
                          input int r1, input bit r1V, input int r1L,
                          input int r2, input bit r2V, input int r2L,
                          input int w, input int act, input logic [63:0] pred);
    tOp = op; tBase[0] = rd; tVec[0] = rdV; tLen[0] = rdL;
    tBase[1] = r1; tVec[1] = r1V; tLen[1] = r1L;
    tBase[2] = r2; tVec[2] = r2V; tLen[2] = r2L;
    tW = w; tAct = act; tPred = pred;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1", inReady === 1'b1 && outValid === 1'b0 && done === 1'b0 && trap === 1'b0,
          {inReady, outValid, done, trap}, 4'b1000, "ports during reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", inReady === 1'b1 && outValid === 1'b0 && done === 1'b0,
          {inReady, outValid, done}, 3'b100, "ports after reset");

    // R2: scalar destination reused, vector sources advance one register per element
    setInstr(8'h33, 2, 0, 1, 4, 1, 3, 4, 1, 3, 0, 3, '1);
    runInstr("R2", 0, 1);
    // R3: 16-bit elements roll into the next register, count 5 cuts the sixth half
    setInstr(8'h11, 2, 1, 3, 2, 1, 3, 9, 0, 1, 2, 5, '1);
    runInstr("R3", 0, 1);
    // R3: 8-bit elements, four per register
    setInstr(8'h12, 30, 1, 4, 8, 1, 4, 16, 1, 4, 1, 13, '1);
    runInstr("R3", 0, 1);
    // R3: reserved width code 6 behaves as full width
    setInstr(8'h13, 1, 1, 4, 3, 1, 4, 7, 0, 1, 6, 4, '1);
    runInstr("R3", 0, 1);
    // R7: everything scalar, predicate empty and count 7 are ignored
    setInstr(8'h44, 5, 0, 1, 6, 0, 1, 7, 0, 1, 0, 7, '0);
    runInstr("R7", 0, 1);
    // R4: sparse predicate, no cycle spent on masked elements
    setInstr(8'h55, 3, 1, 8, 11, 1, 8, 20, 1, 8, 0, 8, 64'hA5);
    runInstr("R4", 0, 1);
    // R5: zero count with vectors issues nothing
    setInstr(8'h56, 3, 1, 8, 11, 1, 8, 20, 1, 8, 0, 0, '1);
    runInstr("R5", 0, 1);
    // R5: count above the maximum is clamped
    setInstr(8'h57, 0, 1, 16, 0, 1, 16, 0, 1, 16, 1, 70, '1);
    runInstr("R5", 0, 1);
    // R6: unequal source lengths
    setInstr(8'h60, 1, 0, 1, 4, 1, 3, 8, 1, 4, 0, 3, '1);
    runInstr("R6", 0, 1);
    // R6: vector destination shorter than source
    setInstr(8'h61, 1, 1, 2, 4, 1, 4, 8, 0, 1, 0, 3, '1);
    runInstr("R6", 0, 1);
    // R6 boundary: equal destination length is accepted
    setInstr(8'h62, 1, 1, 4, 4, 1, 4, 8, 0, 1, 0, 4, '1);
    runInstr("R6", 0, 1);
    // R8: backpressure on a long vector
    setInstr(8'h70, 9, 1, 8, 17, 1, 8, 25, 1, 8, 2, 16, 64'hF0F3);
    runInstr("R8", 1, 0);

    // Random mix
    for (int n = 0; n < 60; n++) begin
      int l1;
      l1 = 1 + int'($urandom % 16);
      setInstr(int'($urandom % 256),
               int'($urandom % 32), bit'($urandom % 2), (($urandom % 4) == 0) ? 1 + int'($urandom % 16) : l1 + int'($urandom % 3),
               int'($urandom % 32), bit'($urandom % 2), l1,
               int'($urandom % 32), bit'($urandom % 2), (($urandom % 4) == 0) ? 1 + int'($urandom % 16) : l1,
               int'($urandom % 8), int'($urandom % 72), {$urandom, $urandom});
      runInstr("R2", bit'($urandom % 2), 0);
    end

    @(negedge clk);
    finishRun();
  end
endmodule